// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a slave-only stereo serial audio port. The bit clock and the word select come from outside the chip. The port receives stereo samples on a serial data input and sends stereo samples on a serial data output. A fast system clock oversamples both external clocks, so all internal logic runs in one synchronous domain. Rising bit-clock edges sample the input data and word select. Falling bit-clock edges advance the output data.

A 3-bit format code selects how samples are framed:

- I2S.
- Left-aligned to the word select edge.
- Right-aligned to the end of each half frame, at 16, 18, 20 or 24 bits.

A separate control bit turns any of the four right-aligned codes into a combined mode. In a combined mode the port receives right-aligned and transmits left-aligned. Received words are presented as a left/right pair of 24-bit values with a one-cycle valid strobe. Transmit words are taken from two 24-bit inputs at the start of each slot.

Top module: `sap_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_valid` and `sdo` are 0. `rx_left` and `rx_right` read 0 after reset.
- R2: Format code 0 (I2S): word select low marks the left slot. The MSB is sampled on the second rising bit-clock edge of a slot. 24 bits are taken MSB first, and later bits of the slot are ignored.
- R3: Format code 1 (left-aligned): word select high marks the left slot. The MSB is sampled on the first rising edge after a word select change. 24 bits are taken MSB first.
- R4: Codes 2, 3, 4 and 5 mean right-aligned reception of 16, 18, 20 and 24 bits, with word select high marking left. The last N bits of each slot form the sample. The sample is placed in bits 23 down to 24-N of the received word, and the lower bits are 0.
- R5: Once per stereo frame, after the right slot ends, `rx_valid` is high for exactly one cycle. In that cycle `rx_left` and `rx_right` take the new pair, and they stay unchanged until the next strobe.
- R6: In I2S, `sdo` is 0 in the first bit of a slot. The next 24 bits carry the word for that slot, MSB first, and any remaining bits are 0.
- R7: In left-aligned transmission, the first bit of a slot carries bit 23 and the following 23 bits carry bits 22..0. All remaining bits of the slot are 0.
- R8: For codes 2 to 5 with `tx_msb` low, the last N bits of a slot carry word bits 23 down to 24-N, MSB first. All earlier bits are 0. The slot length is the length of the previous slot.
- R9: For codes 2 to 5 with `tx_msb` high, transmission is left-aligned as in R7, while reception stays right-aligned as in R4.
- R10: With format code 0 or 1, `tx_msb` has no effect on `sdo`.
- R11: The transmit word is captured on the falling edge that starts its slot. Changes to `tx_left` or `tx_right` during a slot do not alter the bits sent in that slot.
- R12: `sdo` changes only in the cycle after a detected falling bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Format code (0 I2S, 1 left-aligned, 2..5 right-aligned 16/18/20/24) |
| tx_msb | input | 1 | With codes 2..5, transmit left-aligned instead of right-aligned |
| bck | input | 1 | External bit clock |
| ws | input | 1 | External word select |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| tx_left | input | 24 | Left word to transmit |
| tx_right | input | 24 | Right word to transmit |
| rx_left | output | 24 | Last received left word |
| rx_right | output | 24 | Last received right word |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |

## Verification
At a slot boundary, the same rising edge closes the word just received and also captures the first bit of the next slot. Likewise, the same falling edge loads a new transmit word and drives its first bit.

The bench provokes both cases with adjacent words that have only the top bit set, or only the bottom bit set, and with back-to-back random frames. It also changes the transmit inputs halfway through each slot.

It judges the result by comparing every received pair, and every transmitted slot bit by bit, against patterns it builds from the format rules.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_MSBJ  = 3'd1,
        FMT_LSB16 = 3'd2,
        FMT_LSB18 = 3'd3,
        FMT_LSB20 = 3'd4,
        FMT_LSB24 = 3'd5,
        FMT_RSV6  = 3'd6,
        FMT_RSV7  = 3'd7
    } sap_fmt_e;

    typedef enum logic [1:0] {
        JUST_I2S = 2'd0,
        JUST_MSB = 2'd1,
        JUST_LSB = 2'd2
    } sap_just_e;

    typedef struct packed {
        sap_just_e  just;
        logic [4:0] nbits;
    } sap_lane_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } sap_pair_t;

    // Receive framing for a format code; reserved codes fall back to I2S.
    function automatic sap_lane_t rx_lane(logic [2:0] code);
        sap_lane_t l;
        l.just  = JUST_I2S;
        l.nbits = 5'd24;
        case (sap_fmt_e'(code))
            FMT_MSBJ:  l.just = JUST_MSB;
            FMT_LSB16: begin l.just = JUST_LSB; l.nbits = 5'd16; end
            FMT_LSB18: begin l.just = JUST_LSB; l.nbits = 5'd18; end
            FMT_LSB20: begin l.just = JUST_LSB; l.nbits = 5'd20; end
            FMT_LSB24: begin l.just = JUST_LSB; l.nbits = 5'd24; end
            default:   ;
        endcase
        return l;
    endfunction

    // Transmit framing: right-aligned codes may be overridden to left-aligned.
    function automatic sap_lane_t tx_lane(logic [2:0] code, logic msb_out);
        sap_lane_t l;
        l = rx_lane(code);
        if (l.just == JUST_LSB && msb_out) begin
            l.just  = JUST_MSB;
            l.nbits = 5'd24;
        end
        return l;
    endfunction

    // Left-align the last n received bits into a full word.
    function automatic logic [SAMPLE_W-1:0] lsb_align(logic [SAMPLE_W-1:0] sh,
                                                      logic [4:0] n);
        case (n)
            5'd16:   return {sh[15:0], 8'h00};
            5'd18:   return {sh[17:0], 6'h00};
            5'd20:   return {sh[19:0], 4'h0};
            default: return sh;
        endcase
    endfunction

    // Bit sent at slot position pos of a slot len bits long.
    function automatic logic lane_bit(sap_lane_t ln, logic [SAMPLE_W-1:0] w,
                                      int pos, int len);
        logic       b;
        int         r;
        logic [4:0] idx;
        b   = 1'b0;
        idx = 5'd0;
        case (ln.just)
            JUST_I2S: if (pos >= 1 && pos <= SAMPLE_W) begin
                idx = 5'(SAMPLE_W - pos);
                b   = w[idx];
            end
            JUST_MSB: if (pos >= 0 && pos < SAMPLE_W) begin
                idx = 5'(SAMPLE_W - 1 - pos);
                b   = w[idx];
            end
            default: begin
                r = len - 1 - pos;
                if (pos < len && r >= 0 && r < int'(ln.nbits)) begin
                    idx = 5'(SAMPLE_W - int'(ln.nbits) + r);
                    b   = w[idx];
                end
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sap_edge.sv
module sap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bck,
    input  logic ws,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic ws_q,
    output logic sdi_q
);
    localparam int LAST = STAGES - 1;

    // {bck, ws, sdi} travel together so they stay mutually aligned.
    logic [2:0] stage [STAGES];
    logic       bck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= 3'b000;
            bck_last <= 1'b0;
        end else begin
            stage[0] <= {bck, ws, sdi};
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            bck_last <= stage[LAST][2];
        end
    end

    assign rise  =  stage[LAST][2] & ~bck_last;
    assign fall  = ~stage[LAST][2] &  bck_last;
    assign ws_q  =  stage[LAST][1];
    assign sdi_q =  stage[LAST][0];
endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rise,
    input  logic      ws,
    input  logic      sdi,
    input  logic [2:0] fmt,
    output sap_pair_t pair,
    output logic      valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] WORD_N  = CNT_W'(SAMPLE_W);

    sap_lane_t           lane;
    logic                i2s, ws_eff, bnd, slot_left;
    logic                primed, seen, have_left;
    logic                ws_d1, ws_prev;
    logic [CNT_W-1:0]    cnt;
    logic [SAMPLE_W-1:0] msbw, lsw, left_hold, slot_word;
    logic [4:0]          msb_idx;
    sap_pair_t           pair_q;
    logic                valid_q;

    always_comb begin
        lane      = rx_lane(fmt);
        i2s       = (lane.just == JUST_I2S);
        // I2S is treated as left-aligned with word select delayed one bit.
        ws_eff    = i2s ? ws_d1 : ws;
        bnd       = primed && (ws_eff != ws_prev);
        slot_left = i2s ? ~ws_prev : ws_prev;
        slot_word = (lane.just == JUST_LSB) ? lsb_align(lsw, lane.nbits) : msbw;
        msb_idx   = 5'(SAMPLE_W - 1) - cnt[4:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed    <= 1'b0;
            seen      <= 1'b0;
            have_left <= 1'b0;
            ws_d1     <= 1'b0;
            ws_prev   <= 1'b0;
            cnt       <= '0;
            msbw      <= '0;
            lsw       <= '0;
            left_hold <= '0;
            pair_q    <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (rise) begin
                ws_d1 <= ws;
                lsw   <= {lsw[SAMPLE_W-2:0], sdi};
                if (!primed) begin
                    primed  <= 1'b1;
                    ws_prev <= ws;
                    cnt     <= '0;
                    msbw    <= '0;
                end else if (bnd) begin
                    ws_prev <= ws_eff;
                    seen    <= 1'b1;
                    cnt     <= ONE;
                    msbw    <= {sdi, {(SAMPLE_W-1){1'b0}}};
                    if (seen) begin
                        if (slot_left) begin
                            left_hold <= slot_word;
                            have_left <= 1'b1;
                        end else if (have_left) begin
                            pair_q    <= '{left: left_hold, right: slot_word};
                            valid_q   <= 1'b1;
                            have_left <= 1'b0;
                        end
                    end
                end else begin
                    if (cnt < WORD_N) msbw[msb_idx] <= sdi;
                    if (cnt != CNT_MAX) cnt <= cnt + ONE;
                end
            end
        end
    end

    assign pair  = pair_q;
    assign valid = valid_q;
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall,
    input  logic                ws,
    input  logic [2:0]          fmt,
    input  logic                tx_msb,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    sap_lane_t           lane;
    logic                primed, ws_prev, newslot, left_now, bit_n, sdo_q;
    logic [CNT_W-1:0]    tcnt, slot_len, pos_n, len_n;
    logic [SAMPLE_W-1:0] word, word_n;

    always_comb begin
        lane     = tx_lane(fmt, tx_msb);
        newslot  = primed && (ws != ws_prev);
        left_now = (lane.just == JUST_I2S) ? ~ws : ws;
        pos_n    = newslot ? '0 : ((tcnt == CNT_MAX) ? tcnt : tcnt + ONE);
        len_n    = newslot ? tcnt + ONE : slot_len;
        word_n   = newslot ? (left_now ? tx_left : tx_right) : word;
        bit_n    = lane_bit(lane, word_n, int'(pos_n), int'(len_n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            ws_prev  <= 1'b0;
            tcnt     <= '0;
            slot_len <= '0;
            word     <= '0;
            sdo_q    <= 1'b0;
        end else if (fall) begin
            if (!primed) begin
                primed  <= 1'b1;
                ws_prev <= ws;
                tcnt    <= '0;
                sdo_q   <= 1'b0;
            end else begin
                ws_prev <= ws;
                tcnt    <= pos_n;
                if (newslot) slot_len <= len_n;
                word    <= word_n;
                sdo_q   <= bit_n;
            end
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt,
    input  logic                tx_msb,
    input  logic                bck,
    input  logic                ws,
    input  logic                sdi,
    output logic                sdo,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    logic      bck_rise, bck_fall, ws_s, sdi_s;
    sap_pair_t rx_pair;

    sap_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .bck   (bck),
        .ws    (ws),
        .sdi   (sdi),
        .rise  (bck_rise),
        .fall  (bck_fall),
        .ws_q  (ws_s),
        .sdi_q (sdi_s)
    );

    sap_rx #(.CNT_W(CNT_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .rise  (bck_rise),
        .ws    (ws_s),
        .sdi   (sdi_s),
        .fmt   (fmt),
        .pair  (rx_pair),
        .valid (rx_valid)
    );

    sap_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall     (bck_fall),
        .ws       (ws_s),
        .fmt      (fmt),
        .tx_msb   (tx_msb),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sdo      (sdo)
    );

    assign rx_left  = rx_pair.left;
    assign rx_right = rx_pair.right;
endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk
    import sap_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bck_rise,
    input logic                bck_fall,
    input logic [2:0]          fmt,
    input logic                sdo,
    input logic                rx_valid,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rx_valid && !sdo));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r5_words_hold: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rx_left) || !$stable(rx_right)) |-> rx_valid);

    a_r5_valid_after_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bck_rise));

    a_r12_sdo_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(bck_fall));

    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fmt == 3'(FMT_LSB16)) |-> (rx_left[7:0] == 8'h00 && rx_right[7:0] == 8'h00));
endmodule

bind sap_port sap_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bck_rise (bck_rise),
    .bck_fall (bck_fall),
    .fmt      (fmt),
    .sdo      (sdo),
    .rx_valid (rx_valid),
    .rx_left  (rx_left),
    .rx_right (rx_right)
);

// File: tb/sap_port_tb.sv
module sap_port_tb;
    localparam int HB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic        tx_msb = 1'b0;
    logic        bck = 1'b1;
    logic        ws = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [23:0] tx_left = 24'h0;
    logic [23:0] tx_right = 24'h0;
    logic [23:0] rx_left, rx_right;
    logic        rx_valid;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    mon_on = 1'b0;
    int    done_idx = 0;
    int    valid_cnt = 0;
    string rx_req = "R2";

    logic [23:0] RL [16];
    logic [23:0] RR [16];
    logic [23:0] TL [16];
    logic [23:0] TR [16];

    always #5 clk = ~clk;

    sap_port u_dut (
        .clk(clk), .rst(rst), .fmt(fmt), .tx_msb(tx_msb),
        .bck(bck), .ws(ws), .sdi(sdi), .sdo(sdo),
        .tx_left(tx_left), .tx_right(tx_right),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode: 0 = I2S, 1 = left-aligned, N>1 = right-aligned with N bits
    function automatic logic exp_bit(int mode, logic [23:0] w, int k, int s);
        int r;
        if (mode == 0) return (k >= 1 && k <= 24) ? w[24-k] : 1'b0;
        if (mode == 1) return (k < 24) ? w[23-k] : 1'b0;
        r = s - 1 - k;
        return (r < mode) ? w[24-mode+r] : 1'b0;
    endfunction

    function automatic int rx_mode(logic [2:0] f);
        case (f)
            3'd1: return 1;
            3'd2: return 16;
            3'd3: return 18;
            3'd4: return 20;
            3'd5: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int tx_mode(logic [2:0] f, logic m);
        int r;
        r = rx_mode(f);
        if (r > 1 && m) r = 1;
        return r;
    endfunction

    always @(negedge clk) begin
        if (mon_on && rx_valid) begin
            valid_cnt++;
            chk({rx_left, rx_right} === {RL[done_idx], RR[done_idx]},
                {rx_req, " R5 rx pair"}, {16'h0, rx_left, rx_right},
                {16'h0, RL[done_idx], RR[done_idx]});
        end
    end

    task automatic bit_period(input logic ws_v, input logic d, output logic seen);
        @(negedge clk);
        bck = 1'b0; ws = ws_v; sdi = d;
        repeat (HB) @(negedge clk);
        seen = sdo;
        bck = 1'b1;
        repeat (HB - 1) @(negedge clk);
    endtask

    task automatic run_section(input logic [2:0] f_code, input logic m, input int s,
                               input int nfr, input string rxr, input string txr);
        int          mr, mt;
        logic        lvl_left, seen;
        logic [23:0] mask, w, tw;
        logic [63:0] got, expv;
        mr = rx_mode(f_code);
        mt = tx_mode(f_code, m);
        lvl_left = (mr == 0) ? 1'b0 : 1'b1;
        mask = (mr > 1) ? (24'hFFFFFF << (24 - mr)) : 24'hFFFFFF;
        for (int i = 0; i < 16; i++) begin
            RL[i] = 24'h0; RR[i] = 24'h0; TL[i] = 24'h0; TR[i] = 24'h0;
        end
        for (int i = 1; i <= nfr; i++) begin
            RL[i] = 24'($urandom) & mask; RR[i] = 24'($urandom) & mask;
            TL[i] = 24'($urandom);        TR[i] = 24'($urandom);
        end
        // directed extremes: lone top bit next to lone bottom bit
        RL[1] = 24'h800000 & mask; RR[1] = 24'hFFFFFF & mask;
        RL[2] = (24'h000001 << (24 - ((mr > 1) ? mr : 24))) & mask;
        TL[1] = 24'h000001; TR[1] = 24'h800000;

        @(negedge clk);
        rst = 1'b1; fmt = f_code; tx_msb = m; bck = 1'b1; ws = lvl_left; sdi = 1'b0;
        tx_left = 24'h0; tx_right = 24'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(rx_left == 24'h0 && rx_right == 24'h0 && !rx_valid, "R1 reset words",
            {16'h0, rx_left, rx_right}, 64'h0);
        repeat (4) @(negedge clk);
        rx_req = rxr; valid_cnt = 0; done_idx = 0; mon_on = 1'b1;

        for (int f = 0; f <= nfr + 1; f++) begin
            if (f > 0) done_idx = f - 1;
            for (int ch = 0; ch < 2; ch++) begin
                w  = (ch == 0) ? RL[f] : RR[f];
                tw = (ch == 0) ? TL[f] : TR[f];
                got = 64'h0; expv = 64'h0;
                for (int k = 0; k < s; k++) begin
                    if (k == s / 2) begin
                        if (ch == 0) begin
                            tx_left  = 24'($urandom);
                            tx_right = TR[f];
                        end else begin
                            tx_right = 24'($urandom);
                            tx_left  = TL[f + 1];
                        end
                    end
                    bit_period((ch == 0) ? lvl_left : ~lvl_left, exp_bit(mr, w, k, s), seen);
                    got[k]  = seen;
                    expv[k] = exp_bit(mt, tw, k, s);
                end
                if (f >= 1 && f <= nfr)
                    chk(got === expv, {txr, " R11 tx slot"}, got, expv);
            end
        end
        repeat (8) @(negedge clk);
        mon_on = 1'b0;
        chk(valid_cnt == nfr, "R5 pair count", 64'(valid_cnt), 64'(nfr));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!rx_valid && !sdo && rx_left == 24'h0, "R1 reset state",
            {rx_valid, sdo, rx_left}, 64'h0);
        run_section(3'd0, 1'b0, 32, 6, "R2", "R6");
        run_section(3'd1, 1'b0, 32, 6, "R3", "R7");
        run_section(3'd2, 1'b0, 32, 6, "R4", "R8");
        run_section(3'd3, 1'b0, 32, 6, "R4", "R8");
        run_section(3'd4, 1'b0, 32, 6, "R4", "R8");
        run_section(3'd5, 1'b0, 32, 6, "R4", "R8");
        run_section(3'd2, 1'b1, 32, 6, "R4", "R9");
        run_section(3'd5, 1'b1, 32, 6, "R4", "R9");
        run_section(3'd4, 1'b1, 64, 5, "R4", "R9");
        run_section(3'd1, 1'b1, 64, 5, "R3", "R10");
        run_section(3'd0, 1'b1, 32, 6, "R2", "R10");
        // R12: sdo must stay put with the bit clock idle
        begin
            logic hold;
            hold = sdo;
            repeat (40) @(negedge clk);
            chk(sdo === hold, "R12 idle sdo", 64'(sdo), 64'(hold));
        end
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!rx_valid && !sdo && rx_left == 24'h0 && rx_right == 24'h0, "R1 re-reset",
            {16'h0, rx_left, rx_right}, 64'h0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule